// File: doc/BRIEF.md
# Capability Bounds Check Unit

This unit decides whether a memory access, a bounds-narrowing request or a range-containment query stays inside a capability's decoded bounds. The caller supplies the lower bound and an upper limit that is one bit wider than the address, so a limit at the very top of the address space can be expressed. It also supplies an operation code, a permission verdict and the operands. The unit returns only a fault flag and a two-bit cause, and never a data value.

The work is split over two cycles. In the request cycle the operands are reduced to one lower pair and one upper pair and then registered. In the next cycle one lower-bound comparator and one upper-bound comparator resolve the verdict. The upper comparator is strict or inclusive depending on the operation. A flush input discards the registered request and whatever request is presented in the same cycle. The unit is meant to sit beside the execute and memory stages of a pipeline that does not need its result to produce a destination value.

Top module: `bchk_unit`

## Requirements
- R1: Operation code 2'b00 (access) with size > 0 passes only when addr >= base and addr + size - 1 < top. The sum is formed without wrap-around, at address width + 1 bits.
- R2: An access with size 0 passes when base <= addr <= top.
- R3: Operation code 2'b01 (set bounds) passes only when addr >= base and addr + size <= top, so equality with top is accepted.
- R4: top is address width + 1 bits wide. A top of 2^AW admits a last byte at 2^AW - 1. An access whose end crosses 2^AW does not wrap, and fails against any smaller or equal top.
- R5: Operation code 2'b10 (subset) passes only when sub_base >= base and sub_top <= top.
- R6: Operation code 2'b11 is checked exactly like code 2'b00.
- R7: The cause encoding is 2'b00 no fault, 2'b01 length violation and 2'b10 permission violation. A failed permission verdict gives 2'b10 whatever the bounds are. The code 2'b11 never appears. rsp_exc is high exactly when the cause is non-zero.
- R8: A request accepted while flush is low gives rsp_valid, with its verdict, exactly one cycle later. Back-to-back requests are answered in order, one per cycle.
- R9: While flush is high, rsp_valid is low. A request presented in a cycle where flush is high produces no response.
- R10: During and right after reset, and in any cycle without rsp_valid, rsp_valid, rsp_exc and rsp_cause are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Drops the registered request and any same-cycle request |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 2 | 00 access, 01 set bounds, 10 subset, 11 access |
| req_perm_ok | input | 1 | Permission verdict computed elsewhere; 0 forces a permission fault |
| req_addr | input | AW | Lowest byte of the access, or new base for set bounds |
| req_size | input | SZW | Access size in bytes, or requested length |
| req_base | input | AW | Decoded lower bound |
| req_top | input | AW+1 | Decoded upper limit (exclusive) |
| req_sub_base | input | AW | Lower bound of the inner range for subset |
| req_sub_top | input | AW+1 | Upper limit of the inner range for subset |
| rsp_valid | output | 1 | Verdict for the request of the previous cycle |
| rsp_exc | output | 1 | A fault was detected |
| rsp_cause | output | 2 | Fault cause |

## Verification
Accesses are placed just inside, exactly on and one byte past each bound. These cases separate the strict upper comparison from the inclusive one and show that the lower and upper comparators act independently. The same windows are repeated with zero size and with the set-bounds code, which shows that equality with top is accepted only where it should be. A top of 2^64 combined with an access straddling that limit shows whether the upper sum wraps. Subset queries that fail on one side only, permission faults on both good and bad bounds, and a flush landing on a registered request show the priority of causes and the dropping of requests.

// File: rtl/bchk_pkg.sv
// Shared encodings for the capability bounds check unit.
// Assumes: the operation and cause codes are fixed by the interface contract.
package bchk_pkg;
    typedef enum logic [1:0] {
        OP_ACCESS     = 2'b00,
        OP_SETB       = 2'b01,
        OP_SUBSET     = 2'b10,
        OP_ACCESS_ALT = 2'b11
    } bchk_op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_LEN  = 2'b01,
        CAUSE_PERM = 2'b10,
        CAUSE_RSVD = 2'b11
    } bchk_cause_e;
endpackage

// File: rtl/bchk_setup.sv
// Setup stage: reduces the operands of a request to one lower pair (value,
// bound) and one upper pair (value, limit) plus an inclusive-compare flag.
// Assumes: size fits in SZW bits; sums are kept at AW+1 bits, so none wraps.
module bchk_setup #(
    parameter int AW  = 64,
    parameter int SZW = 16
) (
    input  logic [1:0]  op,
    input  logic [AW-1:0] addr,
    input  logic [SZW-1:0] size,
    input  logic [AW-1:0] base,
    input  logic [AW:0]   top,
    input  logic [AW-1:0] sub_base,
    input  logic [AW:0]   sub_top,
    output logic [AW-1:0] lo_val,
    output logic [AW-1:0] lo_lim,
    output logic [AW:0]   hi_val,
    output logic [AW:0]   hi_lim,
    output logic          hi_incl
);
    import bchk_pkg::*;

    localparam int XW = AW + 1;

    logic [XW-1:0] addr_x;
    logic [XW-1:0] size_x;
    logic [XW-1:0] end_excl;
    logic          size_zero;

    // Widen the address and the size, and form the exclusive end at full precision.
    always_comb begin
        addr_x    = {1'b0, addr};
        size_x    = XW'(size);
        end_excl  = addr_x + size_x;
        size_zero = (size == '0);
    end

    // Pick the compared operands and the comparison flavour from the operation.
    always_comb begin
        lo_lim = base;
        hi_lim = top;
        case (bchk_op_e'(op))
            OP_SETB: begin
                lo_val  = addr;
                hi_val  = end_excl;
                hi_incl = 1'b1;
            end
            OP_SUBSET: begin
                lo_val  = sub_base;
                hi_val  = sub_top;
                hi_incl = 1'b1;
            end
            default: begin
                lo_val  = addr;
                hi_val  = size_zero ? addr_x : end_excl - XW'(1);
                hi_incl = size_zero;
            end
        endcase
    end
endmodule

// File: rtl/bchk_stage.sv
// Pipeline register between setup and resolve. A flush clears the valid bit
// and refuses a request presented in the same cycle.
// Assumes: data fields are don't-care while the valid bit is low.
module bchk_stage #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          in_valid,
    input  logic          in_perm_ok,
    input  logic [AW-1:0] in_lo_val,
    input  logic [AW-1:0] in_lo_lim,
    input  logic [AW:0]   in_hi_val,
    input  logic [AW:0]   in_hi_lim,
    input  logic          in_hi_incl,
    output logic          out_valid,
    output logic          out_perm_ok,
    output logic [AW-1:0] out_lo_val,
    output logic [AW-1:0] out_lo_lim,
    output logic [AW:0]   out_hi_val,
    output logic [AW:0]   out_hi_lim,
    output logic          out_hi_incl
);
    // Valid bit: reset and flush clear it, otherwise it follows the request.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid & ~flush;
    end

    // Operand capture: loads only on an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_perm_ok <= 1'b0;
            out_lo_val  <= '0;
            out_lo_lim  <= '0;
            out_hi_val  <= '0;
            out_hi_lim  <= '0;
            out_hi_incl <= 1'b0;
        end else if (in_valid && !flush) begin
            out_perm_ok <= in_perm_ok;
            out_lo_val  <= in_lo_val;
            out_lo_lim  <= in_lo_lim;
            out_hi_val  <= in_hi_val;
            out_hi_lim  <= in_hi_lim;
            out_hi_incl <= in_hi_incl;
        end
    end
endmodule

// File: rtl/bchk_resolve.sv
// Resolve stage: one lower comparator, one upper comparator (strict or
// inclusive), and the cause encoder with permission first.
// Assumes: the operands come straight from the stage register.
module bchk_resolve #(
    parameter int AW = 64
) (
    input  logic          perm_ok,
    input  logic [AW-1:0] lo_val,
    input  logic [AW-1:0] lo_lim,
    input  logic [AW:0]   hi_val,
    input  logic [AW:0]   hi_lim,
    input  logic          hi_incl,
    output logic          fault,
    output logic [1:0]    cause
);
    import bchk_pkg::*;

    logic lo_ok;
    logic hi_ok;

    // Independent comparators for the lowest and the highest checked point.
    always_comb begin
        lo_ok = (lo_val >= lo_lim);
        hi_ok = hi_incl ? (hi_val <= hi_lim) : (hi_val < hi_lim);
    end

    // Fault flag and prioritised cause code.
    always_comb begin
        fault = ~perm_ok | ~lo_ok | ~hi_ok;
        if (!perm_ok)              cause = CAUSE_PERM;
        else if (!(lo_ok && hi_ok)) cause = CAUSE_LEN;
        else                       cause = CAUSE_NONE;
    end
endmodule

// File: rtl/bchk_unit.sv
// Capability bounds check unit top: setup, register, resolve. Outputs are
// forced to zero when no verdict is presented, and a flush hides the
// registered verdict in the same cycle.
// Assumes: the permission verdict is computed upstream.
module bchk_unit #(
    parameter int AW  = 64,
    parameter int SZW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           req_valid,
    input  logic [1:0]     req_op,
    input  logic           req_perm_ok,
    input  logic [AW-1:0]  req_addr,
    input  logic [SZW-1:0] req_size,
    input  logic [AW-1:0]  req_base,
    input  logic [AW:0]    req_top,
    input  logic [AW-1:0]  req_sub_base,
    input  logic [AW:0]    req_sub_top,
    output logic           rsp_valid,
    output logic           rsp_exc,
    output logic [1:0]     rsp_cause
);
    logic [AW-1:0] su_lo_val, su_lo_lim, st_lo_val, st_lo_lim;
    logic [AW:0]   su_hi_val, su_hi_lim, st_hi_val, st_hi_lim;
    logic          su_hi_incl, st_hi_incl, st_valid, st_perm_ok;
    logic          rs_fault;
    logic [1:0]    rs_cause;

    bchk_setup #(.AW(AW), .SZW(SZW)) u_setup (
        .op(req_op), .addr(req_addr), .size(req_size), .base(req_base),
        .top(req_top), .sub_base(req_sub_base), .sub_top(req_sub_top),
        .lo_val(su_lo_val), .lo_lim(su_lo_lim), .hi_val(su_hi_val),
        .hi_lim(su_hi_lim), .hi_incl(su_hi_incl)
    );

    bchk_stage #(.AW(AW)) u_stage (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(req_valid), .in_perm_ok(req_perm_ok),
        .in_lo_val(su_lo_val), .in_lo_lim(su_lo_lim),
        .in_hi_val(su_hi_val), .in_hi_lim(su_hi_lim), .in_hi_incl(su_hi_incl),
        .out_valid(st_valid), .out_perm_ok(st_perm_ok),
        .out_lo_val(st_lo_val), .out_lo_lim(st_lo_lim),
        .out_hi_val(st_hi_val), .out_hi_lim(st_hi_lim), .out_hi_incl(st_hi_incl)
    );

    bchk_resolve #(.AW(AW)) u_resolve (
        .perm_ok(st_perm_ok), .lo_val(st_lo_val), .lo_lim(st_lo_lim),
        .hi_val(st_hi_val), .hi_lim(st_hi_lim), .hi_incl(st_hi_incl),
        .fault(rs_fault), .cause(rs_cause)
    );

    // Output gating: a verdict is shown only when registered and not flushed.
    always_comb begin
        rsp_valid = st_valid & ~flush;
        rsp_exc   = rsp_valid & rs_fault;
        rsp_cause = rsp_valid ? rs_cause : 2'b00;
    end
endmodule

// File: rtl/bchk_unit_chk.sv
// Protocol checker for bchk_unit, bound to every instance.
// Assumes: it sees only the ports of the unit.
module bchk_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flush,
    input logic       req_valid,
    input logic       req_perm_ok,
    input logic       rsp_valid,
    input logic       rsp_exc,
    input logic [1:0] rsp_cause
);
    // R8
    lat_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) && !$past(flush) && !flush |-> rsp_valid);

    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rst_n) && $past(req_valid) && !$past(flush));

    // R9
    flush_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !rsp_valid);

    // R7
    perm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(rst_n) && !$past(req_perm_ok) |-> rsp_cause == 2'b10);

    // R7
    cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cause != 2'b11);

    // R7
    exc_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc == (rsp_cause != 2'b00));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_exc && rsp_cause == 2'b00);
endmodule

bind bchk_unit bchk_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
    .req_perm_ok(req_perm_ok), .rsp_valid(rsp_valid), .rsp_exc(rsp_exc),
    .rsp_cause(rsp_cause)
);

// File: tb/sim_bchk_unit.sv
module sim_bchk_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 64;
    localparam int SZW = 16;
    localparam logic [AW:0] TOP_MAX = {1'b1, {AW{1'b0}}};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           flush = 1'b0;
    logic           req_valid = 1'b0;
    logic [1:0]     req_op = 2'b00;
    logic           req_perm_ok = 1'b1;
    logic [AW-1:0]  req_addr = '0;
    logic [SZW-1:0] req_size = '0;
    logic [AW-1:0]  req_base = '0;
    logic [AW:0]    req_top = '0;
    logic [AW-1:0]  req_sub_base = '0;
    logic [AW:0]    req_sub_top = '0;
    logic           rsp_valid;
    logic           rsp_exc;
    logic [1:0]     rsp_cause;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [1:0] exp_cause_q[$];
    int         exp_cyc_q[$];
    string      exp_tag_q[$];

    bchk_unit #(.AW(AW), .SZW(SZW)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference verdict written from the requirements.
    function automatic logic [1:0] model(input logic [1:0] op, input logic perm,
            input logic [AW-1:0] addr, input logic [SZW-1:0] size,
            input logic [AW-1:0] base, input logic [AW:0] top,
            input logic [AW-1:0] sb, input logic [AW:0] st);
        logic [AW:0] a;
        logic [AW:0] s;
        bit ok;
        a = {1'b0, addr};
        s = {{(AW+1-SZW){1'b0}}, size};
        if (!perm) return 2'b10;
        case (op)
            2'b01:   ok = (addr >= base) && (a + s <= top);
            2'b10:   ok = (sb >= base) && (st <= top);
            default: ok = (size == 0) ? ((addr >= base) && (a <= top))
                                      : ((addr >= base) && (a + s - 1 < top));
        endcase
        return ok ? 2'b00 : 2'b01;
    endfunction

    // Driver: presents one request in the next cycle and queues its verdict.
    task automatic send(input logic [1:0] op, input logic perm,
            input logic [AW-1:0] addr, input logic [SZW-1:0] size,
            input logic [AW-1:0] base, input logic [AW:0] top,
            input logic [AW-1:0] sb, input logic [AW:0] st, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_perm_ok = perm; req_addr = addr;
        req_size = size; req_base = base; req_top = top;
        req_sub_base = sb; req_sub_top = st;
        exp_cause_q.push_back(model(op, perm, addr, size, base, top, sb, st));
        exp_cyc_q.push_back(cyc + 1);
        exp_tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compares each verdict with the queued expectation and its cycle.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (rst_n && rsp_valid) begin
                if (exp_cause_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected response", 1, 0);
                end else begin
                    logic [1:0] ec;
                    int ecy;
                    string et;
                    ec = exp_cause_q.pop_front();
                    ecy = exp_cyc_q.pop_front();
                    et = exp_tag_q.pop_front();
                    chk(rsp_cause == ec, {et, " cause"}, rsp_cause, ec);
                    chk(rsp_exc == (ec != 2'b00), {et, " R7 exc"}, rsp_exc, ec != 2'b00);
                    chk(cyc == ecy, {et, " R8 latency"}, cyc, ecy);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/4);
        chk(!rsp_valid && !rsp_exc && rsp_cause == 2'b00, "R10 reset outputs", rsp_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        chk(!rsp_valid && rsp_cause == 2'b00, "R10 after reset", rsp_valid, 0);

        // R1 strict top with lower and upper edges
        send(2'b00, 1, 1000, 8, 1000, 2000, 0, 0, "R1 at base");
        send(2'b00, 1, 1992, 8, 1000, 2000, 0, 0, "R1 last byte");
        send(2'b00, 1, 1993, 8, 1000, 2000, 0, 0, "R1 one past top");
        send(2'b00, 1,  999, 8, 1000, 2000, 0, 0, "R1 below base");
        // R2 zero size
        send(2'b00, 1, 2000, 0, 1000, 2000, 0, 0, "R2 zero at top");
        send(2'b00, 1, 2001, 0, 1000, 2000, 0, 0, "R2 zero past top");
        send(2'b00, 1,  999, 0, 1000, 2000, 0, 0, "R2 zero below base");
        // R3 inclusive top for set bounds
        send(2'b01, 1, 1992, 8, 1000, 2000, 0, 0, "R3 end equals top");
        send(2'b01, 1, 1992, 9, 1000, 2000, 0, 0, "R3 end past top");
        send(2'b01, 1,  998, 4, 1000, 2000, 0, 0, "R3 below base");
        // R4 extended top
        send(2'b00, 1, 64'hFFFF_FFFF_FFFF_FFF8, 8, 0, TOP_MAX, 0, 0, "R4 last byte of space");
        send(2'b00, 1, 64'hFFFF_FFFF_FFFF_FFFC, 8, 0, TOP_MAX, 0, 0, "R4 no wrap");
        send(2'b01, 1, 64'hFFFF_FFFF_FFFF_FFF8, 8, 0, TOP_MAX, 0, 0, "R4 set to full top");
        send(2'b00, 1, 64'hFFFF_FFFF_FFFF_FFFC, 8, 0, 65'h0_FFFF_FFFF_FFFF_FFFF, 0, 0, "R4 narrow top");
        // R5 subset
        send(2'b10, 1, 0, 0, 1000, 2000, 1200, 2000, "R5 inside");
        send(2'b10, 1, 0, 0, 1000, 2000, 1200, 2001, "R5 top over");
        send(2'b10, 1, 0, 0, 1000, 2000,  999, 1500, "R5 base under");
        send(2'b10, 1, 0, 0, 1000, 2000, 1000, 1000, "R5 empty at base");
        // R6 alternate access code
        send(2'b11, 1, 1993, 8, 1000, 2000, 0, 0, "R6 past top");
        send(2'b11, 1, 1000, 0, 1000, 2000, 0, 0, "R6 zero ok");
        // R7 permission priority
        send(2'b00, 0, 1000, 8, 1000, 2000, 0, 0, "R7 perm in bounds");
        send(2'b00, 0,  500, 8, 1000, 2000, 0, 0, "R7 perm out of bounds");
        send(2'b10, 0, 0, 0, 1000, 2000, 1, 5000, "R7 perm subset");
        idle();
        repeat (2) idle();

        // R9 flush drops the registered request and the concurrent one
        send(2'b00, 1, 1993, 8, 1000, 2000, 0, 0, "R9 flushed");
        @(negedge clk);
        void'(exp_cause_q.pop_back());
        void'(exp_cyc_q.pop_back());
        void'(exp_tag_q.pop_back());
        flush = 1'b1;
        req_addr = 500;
        #(CLK_PERIOD/4);
        chk(!rsp_valid, "R9 flush hides registered", rsp_valid, 0);
        @(negedge clk);
        flush = 1'b0;
        req_valid = 1'b0;
        #(CLK_PERIOD/4);
        chk(!rsp_valid && !rsp_exc, "R9 same-cycle request dropped", rsp_valid, 0);
        send(2'b00, 1, 1000, 8, 1000, 2000, 0, 0, "R9 after flush");
        repeat (3) idle();

        chk(exp_cause_q.size() == 0, "R8 all answered", exp_cause_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R8 watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule